// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the hardwired control unit of a small single-bus accumulator processor. It walks every instruction through a chain of machine cycles: fetch, pointer read (repeated for each level of indirection), operand read, execute, store, and an interrupt-service cycle placed between instructions. Each machine cycle is split into four clock beats, T1 to T4. A memory-touching cycle can stretch by inserting wait beats between T3 and T4 until memory reports ready.

The sequencer reads decoded instruction attributes: an indirect flag, source-in-memory, destination-in-memory and a two-bit instruction class. It also reads a "further indirection" flag for the pointer just loaded, a memory-ready line and an interrupt request. It drives a vector of micro-command strobes, one line per register transfer or operation, and exposes its current cycle and beat. The attributes must be valid from the fetch T4 beat until the instruction ends. The datapath that obeys the strobes is outside this block.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge the sequencer goes to fetch cycle (code 0) at beat T1 (code 0). While `rst_n` is low, every strobe is 0. The first beat after release is fetch/T1.
- R2: Beats run T1(0), T2(1), T3(2), T4(4), then T1 again. The execute cycle (code 3) never inserts a wait beat, whatever `mem_ready` is.
- R3: In every cycle other than execute, a T3 or wait beat whose `mem_ready` is low is followed by a wait beat TW (code 3). The first such beat with `mem_ready` high is followed by T4. Strobes during TW equal those of T3 of the same cycle.
- R4: Fetch strobes are as follows. T1: PC_OUT, MAR_IN and READ. T2: READ and PC_INC. T3/TW: READ and MDR_IN. T4: MDR_OUT and IR_IN. Strobe bits are PC_OUT 0, PC_INC 1, PC_LOAD 2, MAR_IN 3, READ 4, WRITE 5, MDR_IN 6, MDR_LD 7, MDR_OUT 8, IR_IN 9, IR_ADDR_OUT 10, AC_IN 11, AC_OUT 12, ALU_OP 13, SHIFT_OP 14, VEC_OUT 15, INT_ACK 16.
- R5: After fetch, the next cycle is chosen in this order. If `ir_indirect` is set, it is pointer read (code 1). Otherwise, if `ir_src_mem` is set, it is operand read (code 2). Otherwise it is execute.
- R6: Pointer read repeats while `ind_more` is high at its T4. It then continues to operand read or execute according to `ir_src_mem`. The first pointer read drives the address with IR_ADDR_OUT and later ones with MDR_OUT. Both assert MAR_IN and READ at T1, READ at T2, READ and MDR_IN at T3/TW, and nothing at T4.
- R7: Operand read puts out its address at T1 with MAR_IN and READ. The address comes from MDR_OUT when the instruction is indirect and from IR_ADDR_OUT otherwise. It asserts READ at T2, READ and MDR_IN at T3/TW, and nothing at T4. It is always followed by execute.
- R8: Execute strobes depend on `ir_class`. The operand source is MDR_OUT when `ir_src_mem` is set, else IR_ADDR_OUT. Class 0 (arithmetic) drives the source with ALU_OP at T2 and AC_IN at T4. Class 1 (shift) does the same with SHIFT_OP. Class 2 (move) drives the source with AC_IN at T4. Class 3 (jump) drives PC_LOAD at T2, with the target from MDR_OUT if indirect, else IR_ADDR_OUT. At most one bus source is driven in any beat.
- R9: Execute is followed by store (code 4) only when `ir_dst_mem` is set. Store strobes are as follows. T1: MAR_IN, with the address from MDR_OUT if indirect, else IR_ADDR_OUT. T2: AC_OUT and MDR_LD. T3/TW: WRITE. T4: none.
- R10: At the end of an instruction (execute T4 without store, or store T4), `irq_req` high leads to the interrupt cycle (code 5); otherwise the next cycle is fetch. The interrupt cycle asserts PC_OUT, MDR_LD and INT_ACK at T1; VEC_OUT and MAR_IN at T2; WRITE at T3/TW; VEC_OUT and PC_LOAD at T4. It is always followed by fetch. `irq_req` at any other beat has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_indirect | input | 1 | Instruction uses indirect addressing |
| ir_src_mem | input | 1 | Source operand lives in memory or I/O |
| ir_dst_mem | input | 1 | Destination operand lives in memory or I/O |
| ir_class | input | CLASS_W | Instruction class: 0 arithmetic, 1 shift, 2 move, 3 jump |
| ind_more | input | 1 | Pointer just read is itself indirect |
| mem_ready | input | 1 | Memory access can complete this beat |
| irq_req | input | 1 | Pending interrupt request |
| strobe_o | output | 17 | Micro-command strobes, bit map in R4 |
| cyc_o | output | 3 | Current machine cycle code |
| beat_o | output | 3 | Current beat code |

## Verification
The bench builds the block with the default CLASS_W of 2, so all four instruction classes can be driven and every execute branch is reached. A bench model follows the cycle chain and compares the cycle, beat and strobe vector every clock. The directed opening instruction has a three-level pointer chain, long wait stretches and an interrupt after a store, and it is followed by a direct jump. Random instructions then mix the attributes with random memory waits, including low ready during execute. A mid-run reset lets the bench check that the reset behaviour also holds in the middle of operation.

// File: rtl/seq_pkg.sv
// Shared encodings for the instruction-cycle sequencer: cycle and beat
// codes plus the bit positions of the micro-command strobe vector.
package seq_pkg;

    typedef enum logic [2:0] {
        C_FETCH = 3'd0,
        C_INDIR = 3'd1,
        C_OPRD  = 3'd2,
        C_EXEC  = 3'd3,
        C_STORE = 3'd4,
        C_INTR  = 3'd5
    } cyc_t;

    typedef enum logic [2:0] {
        B_T1 = 3'd0,
        B_T2 = 3'd1,
        B_T3 = 3'd2,
        B_TW = 3'd3,
        B_T4 = 3'd4
    } beat_t;

    localparam int S_PC_OUT      = 0;
    localparam int S_PC_INC      = 1;
    localparam int S_PC_LOAD     = 2;
    localparam int S_MAR_IN      = 3;
    localparam int S_READ        = 4;
    localparam int S_WRITE       = 5;
    localparam int S_MDR_IN      = 6;
    localparam int S_MDR_LD      = 7;
    localparam int S_MDR_OUT     = 8;
    localparam int S_IR_IN       = 9;
    localparam int S_IR_ADDR_OUT = 10;
    localparam int S_AC_IN       = 11;
    localparam int S_AC_OUT      = 12;
    localparam int S_ALU_OP      = 13;
    localparam int S_SHIFT_OP    = 14;
    localparam int S_VEC_OUT     = 15;
    localparam int S_INT_ACK     = 16;
    localparam int NUM_STROBES   = 17;

    localparam logic [1:0] K_ARITH = 2'd0;
    localparam logic [1:0] K_SHIFT = 2'd1;
    localparam logic [1:0] K_MOVE  = 2'd2;
    localparam logic [1:0] K_JUMP  = 2'd3;

endpackage

// File: rtl/seq_beat_timer.sv
// Beat timer: steps T1, T2, T3, T4 inside one machine cycle and holds in
// the wait beat between T3 and T4 while memory is not ready.
// Assumes wait_en is high only for cycles that access memory.
module seq_beat_timer
    import seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wait_en,
    input  logic  mem_ready,
    output beat_t beat_q,
    output logic  last_beat
);

    beat_t beat_d;

    // Next-beat selection, wait beat only after T3 or another wait beat.
    always_comb begin
        case (beat_q)
            B_T1:    beat_d = B_T2;
            B_T2:    beat_d = B_T3;
            B_T3:    beat_d = (wait_en && !mem_ready) ? B_TW : B_T4;
            B_TW:    beat_d = mem_ready ? B_T4 : B_TW;
            B_T4:    beat_d = B_T1;
            default: beat_d = B_T1;
        endcase
    end

    // Beat register with synchronous reset to T1.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= B_T1;
        else        beat_q <= beat_d;
    end

    assign last_beat = (beat_q == B_T4);

    // R3: a wait beat only follows T3 or a wait beat.
    p_tw_after_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q == B_TW) |-> ($past(beat_q) == B_T3 || $past(beat_q) == B_TW));

    // R3: leaving a memory cycle's T3/TW for T4 needs ready high.
    p_t4_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q == B_T4) |-> ($past(mem_ready) || !$past(wait_en)));

    // R2: T2 always follows T1.
    p_t2_after_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q == B_T2) |-> ($past(beat_q) == B_T1));

endmodule

// File: rtl/seq_cycle_fsm.sv
// Machine-cycle selector: at the last beat of each cycle picks the next
// cycle through the fixed chain pointer read -> operand read -> execute ->
// store, then interrupt or fetch. Assumes decode attributes are stable from
// fetch T4 to the end of the instruction.
module seq_cycle_fsm
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic ir_indirect,
    input  logic ir_src_mem,
    input  logic ir_dst_mem,
    input  logic ind_more,
    input  logic irq_req,
    input  beat_t beat_q,
    output cyc_t cyc_q,
    output logic first_ptr_q
);

    cyc_t cyc_d;
    logic after_ptr;
    logic end_instr;

    assign after_ptr = 1'b1;

    // Next-cycle chain evaluated every beat, used only at T4.
    always_comb begin
        end_instr = 1'b0;
        case (cyc_q)
            C_FETCH: cyc_d = ir_indirect ? C_INDIR : (ir_src_mem ? C_OPRD : C_EXEC);
            C_INDIR: cyc_d = ind_more ? C_INDIR : (ir_src_mem ? C_OPRD : C_EXEC);
            C_OPRD:  cyc_d = C_EXEC;
            C_EXEC: begin
                end_instr = !ir_dst_mem;
                cyc_d     = ir_dst_mem ? C_STORE : (irq_req ? C_INTR : C_FETCH);
            end
            C_STORE: begin
                end_instr = after_ptr;
                cyc_d     = irq_req ? C_INTR : C_FETCH;
            end
            C_INTR:  cyc_d = C_FETCH;
            default: cyc_d = C_FETCH;
        endcase
    end

    // Cycle register and first-pointer flag, updated at the end of T4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q       <= C_FETCH;
            first_ptr_q <= 1'b1;
        end else if (adv) begin
            cyc_q       <= cyc_d;
            first_ptr_q <= (cyc_q == C_FETCH);
        end
    end

    // R2: the cycle only changes when a new T1 starts.
    p_cyc_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q != B_T1) |-> $stable(cyc_q));

    // R6: a pointer read is entered only for indirect instructions.
    p_indir_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == C_INDIR && beat_q == B_T1) |-> $past(ir_indirect));

    // R9: store always directly follows execute.
    p_store_after_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == C_STORE && beat_q == B_T1) |-> ($past(cyc_q) == C_EXEC && $past(ir_dst_mem)));

    // R10: interrupt cycle only at an instruction end with a request.
    p_intr_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == C_INTR && beat_q == B_T1) |->
        ($past(irq_req) && ($past(cyc_q) == C_EXEC || $past(cyc_q) == C_STORE) && $past(end_instr)));

endmodule

// File: rtl/seq_strobe_gen.sv
// Strobe generator: decodes cycle, beat and instruction attributes into
// the micro-command strobe vector for a single internal bus.
// Assumes the wait beat repeats the T3 strobes of its cycle.
module seq_strobe_gen
    import seq_pkg::*;
#(
    parameter int CLASS_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cyc_t               cyc_q,
    input  beat_t              beat_q,
    input  logic               first_ptr_q,
    input  logic               ir_indirect,
    input  logic               ir_src_mem,
    input  logic [CLASS_W-1:0] ir_class,
    output logic [NUM_STROBES-1:0] strobe
);

    logic [NUM_STROBES-1:0] raw;
    logic mid;      // T3 or wait beat
    int   src_bit;  // bus source for the execute operand
    int   adr_bit;  // bus source for an operand or store address
    logic [1:0] kind;

    assign mid     = (beat_q == B_T3) || (beat_q == B_TW);
    assign src_bit = ir_src_mem  ? S_MDR_OUT : S_IR_ADDR_OUT;
    assign adr_bit = ir_indirect ? S_MDR_OUT : S_IR_ADDR_OUT;
    assign kind    = ir_class[1:0];

    // Per-cycle strobe decode by beat.
    always_comb begin
        raw = '0;
        case (cyc_q)
            C_FETCH: begin
                if (beat_q == B_T1) begin
                    raw[S_PC_OUT] = 1'b1; raw[S_MAR_IN] = 1'b1; raw[S_READ] = 1'b1;
                end
                if (beat_q == B_T2) begin
                    raw[S_READ] = 1'b1; raw[S_PC_INC] = 1'b1;
                end
                if (mid) begin
                    raw[S_READ] = 1'b1; raw[S_MDR_IN] = 1'b1;
                end
                if (beat_q == B_T4) begin
                    raw[S_MDR_OUT] = 1'b1; raw[S_IR_IN] = 1'b1;
                end
            end
            C_INDIR, C_OPRD: begin
                if (beat_q == B_T1) begin
                    if (cyc_q == C_INDIR)
                        raw[first_ptr_q ? S_IR_ADDR_OUT : S_MDR_OUT] = 1'b1;
                    else
                        raw[adr_bit] = 1'b1;
                    raw[S_MAR_IN] = 1'b1; raw[S_READ] = 1'b1;
                end
                if (beat_q == B_T2) raw[S_READ] = 1'b1;
                if (mid) begin
                    raw[S_READ] = 1'b1; raw[S_MDR_IN] = 1'b1;
                end
            end
            C_EXEC: begin
                if ((CLASS_W <= 2 || ir_class[CLASS_W-1:0] < 4)) begin
                    case (kind)
                        K_ARITH, K_SHIFT: begin
                            if (beat_q == B_T2) begin
                                raw[src_bit] = 1'b1;
                                raw[(kind == K_ARITH) ? S_ALU_OP : S_SHIFT_OP] = 1'b1;
                            end
                            if (beat_q == B_T4) raw[S_AC_IN] = 1'b1;
                        end
                        K_MOVE: begin
                            if (beat_q == B_T4) begin
                                raw[src_bit] = 1'b1; raw[S_AC_IN] = 1'b1;
                            end
                        end
                        default: begin
                            if (beat_q == B_T2) begin
                                raw[adr_bit] = 1'b1; raw[S_PC_LOAD] = 1'b1;
                            end
                        end
                    endcase
                end
            end
            C_STORE: begin
                if (beat_q == B_T1) begin
                    raw[adr_bit] = 1'b1; raw[S_MAR_IN] = 1'b1;
                end
                if (beat_q == B_T2) begin
                    raw[S_AC_OUT] = 1'b1; raw[S_MDR_LD] = 1'b1;
                end
                if (mid) raw[S_WRITE] = 1'b1;
            end
            C_INTR: begin
                if (beat_q == B_T1) begin
                    raw[S_PC_OUT] = 1'b1; raw[S_MDR_LD] = 1'b1; raw[S_INT_ACK] = 1'b1;
                end
                if (beat_q == B_T2) begin
                    raw[S_VEC_OUT] = 1'b1; raw[S_MAR_IN] = 1'b1;
                end
                if (mid) raw[S_WRITE] = 1'b1;
                if (beat_q == B_T4) begin
                    raw[S_VEC_OUT] = 1'b1; raw[S_PC_LOAD] = 1'b1;
                end
            end
            default: raw = '0;
        endcase
    end

    // Strobes held idle while reset is asserted.
    assign strobe = rst_n ? raw : '0;

    // R8: single internal bus, never more than one source driving it.
    p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({strobe[S_PC_OUT], strobe[S_MDR_OUT], strobe[S_IR_ADDR_OUT],
                    strobe[S_AC_OUT], strobe[S_VEC_OUT]}) <= 1);

    // R3: memory read and write never requested together.
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe[S_READ] && strobe[S_WRITE]));

    // R3: a wait beat repeats the strobes of the beat before it.
    p_tw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q == B_TW) |-> $stable(strobe));

endmodule

// File: rtl/instr_cycle_seq.sv
// Top of the hardwired instruction-cycle sequencer: ties the beat timer,
// the machine-cycle selector and the strobe generator together.
// Assumes decode attributes are valid from fetch T4 until the instruction
// ends, and that ind_more is valid at the T4 of each pointer read.
module instr_cycle_seq
    import seq_pkg::*;
#(
    parameter int CLASS_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ir_indirect,
    input  logic                   ir_src_mem,
    input  logic                   ir_dst_mem,
    input  logic [CLASS_W-1:0]     ir_class,
    input  logic                   ind_more,
    input  logic                   mem_ready,
    input  logic                   irq_req,
    output logic [NUM_STROBES-1:0] strobe_o,
    output logic [2:0]             cyc_o,
    output logic [2:0]             beat_o
);

    beat_t beat_q;
    cyc_t  cyc_q;
    logic  last_beat;
    logic  first_ptr_q;
    logic  wait_en;

    // Only execute runs without memory, so only it ignores ready.
    assign wait_en = (cyc_q != C_EXEC);

    seq_beat_timer u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_en   (wait_en),
        .mem_ready (mem_ready),
        .beat_q    (beat_q),
        .last_beat (last_beat)
    );

    seq_cycle_fsm u_cyc (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (last_beat),
        .ir_indirect (ir_indirect),
        .ir_src_mem  (ir_src_mem),
        .ir_dst_mem  (ir_dst_mem),
        .ind_more    (ind_more),
        .irq_req     (irq_req),
        .beat_q      (beat_q),
        .cyc_q       (cyc_q),
        .first_ptr_q (first_ptr_q)
    );

    seq_strobe_gen #(.CLASS_W(CLASS_W)) u_strb (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_q       (cyc_q),
        .beat_q      (beat_q),
        .first_ptr_q (first_ptr_q),
        .ir_indirect (ir_indirect),
        .ir_src_mem  (ir_src_mem),
        .ir_class    (ir_class),
        .strobe      (strobe_o)
    );

    assign cyc_o  = cyc_q;
    assign beat_o = beat_q;

    // R1: first beat after reset release is fetch at T1.
    p_reset_start_r1: assert property (@(posedge clk)
        !rst_n |=> (cyc_o == 3'd0 && beat_o == 3'd0));

    // R2: execute never enters the wait beat.
    p_exec_no_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == 3'd3) |-> (beat_o != 3'd3));

endmodule

// File: tb/sim_instr_cycle_seq.sv
`timescale 1ns/1ps
module sim_instr_cycle_seq;

    localparam int CW = 2;
    localparam int NS = 17;
    // cycle and beat codes, from the requirements
    localparam int FE = 0, IN = 1, OP = 2, EX = 3, ST = 4, IT = 5;
    localparam int T1 = 0, T2 = 1, T3 = 2, TW = 3, T4 = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_indirect = 1'b0, ir_src_mem = 1'b0, ir_dst_mem = 1'b0;
    logic [CW-1:0] ir_class = '0;
    logic ind_more = 1'b0, mem_ready = 1'b1, irq_req = 1'b0;
    logic [NS-1:0] strobe_o;
    logic [2:0] cyc_o, beat_o;

    instr_cycle_seq #(.CLASS_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_indirect(ir_indirect), .ir_src_mem(ir_src_mem),
        .ir_dst_mem(ir_dst_mem), .ir_class(ir_class), .ind_more(ind_more),
        .mem_ready(mem_ready), .irq_req(irq_req), .strobe_o(strobe_o),
        .cyc_o(cyc_o), .beat_o(beat_o)
    );

    always #2 clk = ~clk;

    int total = 0, fails = 0;
    bit done = 1'b0;
    int m_cyc, m_beat, prev_beat, instr_no, wait_left, indir_visits;
    bit m_first;
    string ctag;

    task automatic chk(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0h exp %0h (instr %0d)", tag, what, got, exp, instr_no);
        end
    endtask

    // expected strobe vector from the R4..R10 tables
    function automatic logic [NS-1:0] exp_strobe(int c, int b, bit first, bit ind, bit src,
                                                 int cls);
        logic [NS-1:0] s = '0;
        bit md = (b == T3 || b == TW);
        int opnd = src ? 8 : 10;
        int adr  = ind ? 8 : 10;
        case (c)
            FE: begin
                if (b == T1) begin s[0] = 1; s[3] = 1; s[4] = 1; end
                if (b == T2) begin s[4] = 1; s[1] = 1; end
                if (md)      begin s[4] = 1; s[6] = 1; end
                if (b == T4) begin s[8] = 1; s[9] = 1; end
            end
            IN, OP: begin
                if (b == T1) begin
                    if (c == IN) s[first ? 10 : 8] = 1; else s[adr] = 1;
                    s[3] = 1; s[4] = 1;
                end
                if (b == T2) s[4] = 1;
                if (md) begin s[4] = 1; s[6] = 1; end
            end
            EX: begin
                if (cls == 0 || cls == 1) begin
                    if (b == T2) begin s[opnd] = 1; s[cls == 0 ? 13 : 14] = 1; end
                    if (b == T4) s[11] = 1;
                end else if (cls == 2) begin
                    if (b == T4) begin s[opnd] = 1; s[11] = 1; end
                end else begin
                    if (b == T2) begin s[adr] = 1; s[2] = 1; end
                end
            end
            ST: begin
                if (b == T1) begin s[adr] = 1; s[3] = 1; end
                if (b == T2) begin s[12] = 1; s[7] = 1; end
                if (md) s[5] = 1;
            end
            IT: begin
                if (b == T1) begin s[0] = 1; s[7] = 1; s[16] = 1; end
                if (b == T2) begin s[15] = 1; s[3] = 1; end
                if (md) s[5] = 1;
                if (b == T4) begin s[15] = 1; s[2] = 1; end
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic string strobe_tag(int c);
        case (c)
            FE: return "R4";
            IN: return "R6";
            OP: return "R7";
            EX: return "R8";
            ST: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model_init();
        m_cyc = FE; m_beat = T1; m_first = 1; prev_beat = T1;
        ctag = "R1"; indir_visits = 0; wait_left = 0;
    endtask

    // one beat: check, drive inputs for the coming edge, advance the model
    task automatic step();
        int nb, nc;
        string btag;
        btag = (m_beat == TW || prev_beat == T3 || prev_beat == TW) ? "R3" : "R2";
        if (ctag == "R1") btag = "R1";
        chk(btag, "beat", int'(beat_o), m_beat);
        chk(ctag, "cycle", int'(cyc_o), m_cyc);
        chk(strobe_tag(m_cyc), "strobes", int'(strobe_o),
            int'(exp_strobe(m_cyc, m_beat, m_first, ir_indirect, ir_src_mem, int'(ir_class))));

        if (m_cyc == FE && m_beat == T1) begin
            if (instr_no == 0) begin
                ir_indirect = 1; ir_src_mem = 1; ir_dst_mem = 1; ir_class = 2'd0;
            end else if (instr_no == 1) begin
                ir_indirect = 0; ir_src_mem = 0; ir_dst_mem = 0; ir_class = 2'd3;
            end else begin
                ir_indirect = $urandom % 2; ir_src_mem = $urandom % 2;
                ir_dst_mem = $urandom % 2; ir_class = CW'($urandom % 4);
            end
        end
        if (m_beat == T3 || m_beat == TW) begin
            mem_ready = (wait_left == 0);
            if (wait_left > 0) wait_left--;
        end else begin
            mem_ready = $urandom % 2;
        end
        if (instr_no == 0) begin
            ind_more = (m_cyc == IN && indir_visits < 3);
            irq_req  = 1;
        end else if (instr_no == 1) begin
            ind_more = $urandom % 2; irq_req = 0;
        end else begin
            ind_more = ($urandom % 3 == 0); irq_req = ($urandom % 4 == 0);
        end

        // model of R2/R3 beat order
        case (m_beat)
            T1: nb = T2;
            T2: nb = T3;
            T3: nb = (m_cyc != EX && !mem_ready) ? TW : T4;
            TW: nb = mem_ready ? T4 : TW;
            default: nb = T1;
        endcase
        nc = m_cyc;
        ctag = "R2";
        if (m_beat == T4) begin
            case (m_cyc)
                FE: begin nc = ir_indirect ? IN : (ir_src_mem ? OP : EX); ctag = "R5"; end
                IN: begin nc = ind_more ? IN : (ir_src_mem ? OP : EX); ctag = "R6"; end
                OP: begin nc = EX; ctag = "R7"; end
                EX: begin nc = ir_dst_mem ? ST : (irq_req ? IT : FE);
                          ctag = ir_dst_mem ? "R9" : "R10"; end
                default: begin nc = (m_cyc == ST && irq_req) ? IT : FE; ctag = "R10"; end
            endcase
            m_first = (m_cyc == FE);
            if (nc == IN) indir_visits++;
            if (nc == FE) begin instr_no++; indir_visits = 0; end
        end
        if (nb == T3) wait_left = (instr_no == 0) ? 5 : (($urandom % 3 == 0) ? $urandom % 4 : 0);
        prev_beat = m_beat;
        m_beat = nb;
        m_cyc  = nc;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) begin
            @(negedge clk); #1;
            chk("R1", "strobes in reset", int'(strobe_o), 0);
        end
        @(negedge clk);
        rst_n = 1;
        model_init();
        #1;
        step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        instr_no = 0;
        do_reset();
        while (instr_no < 500) begin
            @(negedge clk); #1;
            if (instr_no == 250 && m_cyc == FE && m_beat == T1) begin
                instr_no++;
                do_reset();
            end else begin
                step();
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: run did not finish (got hang, exp completion)");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule